// File: doc/BRIEF.md
# Serial Command Receiver for a Dot-Matrix Display Controller

This block takes a byte stream from a host over a three-wire link (shift clock, data, active-low select) and turns it into register updates and memory writes for a dot-matrix display controller. The link signals are brought into the system clock domain through a two-flop synchronizer. Each rising edge of the shift clock is detected there and moves in one data bit. Every eighth bit completes a byte without any external latch pulse. The system clock must run at least four times faster than the shift clock.

The first byte after select goes low is a command. Its upper nibble picks the action. Four commands are single-byte register settings: the two static port outputs, a three-bit duty code, a three-bit digit-count code, and a pair of force-off/force-on bits. The other three commands open a streaming write into one of three display memories, starting at an address carried in the low bits of the command. These are a 16-entry character-code memory of 8 bits per entry, an 8-entry glyph memory of 35 bits per entry, and a 16-entry marker memory of 2 bits per entry. Later bytes are written at an auto-incrementing pointer until select goes high again. Glyph entries are assembled from five bytes, each byte carrying one column of the 5x7 cell.

The outputs are single-cycle write strobes with address and data for each memory, plus the current register values. The display scan, the glyph ROM and the output drivers lie outside this block.

Top module: `vfd_cmd_rx`

## Requirements
- R1: A data bit is taken on each rising edge of `link_clk` while `link_csn` is low, and bits arrive least significant first. Shift clock edges while `link_csn` is high move no data and cause no write or register change.
- R2: A high level on `link_csn` discards any partly received byte. The next byte is counted from the first rising edge after `link_csn` returns low.
- R3: A command byte with upper nibble 0x1 starts a character-code stream at address bits [3:0]. Each later byte is written whole to `chr_addr`, and the pointer then advances, wrapping from 15 to 0. Command-like values inside a stream are stored as data.
- R4: A command byte with upper nibble 0x2 starts a glyph stream at address bits [2:0]. Five later bytes form one 35-bit word: byte k (k = 0..4) supplies word bits k+5*j from its bits j = 0..6, and its bit 7 is ignored. The word is written after the fifth byte, and the pointer then advances, wrapping from 7 to 0.
- R5: A command byte with upper nibble 0x3 starts a marker stream at address bits [3:0]. Only bits [1:0] of each later byte are written, and the pointer wraps from 15 to 0.
- R6: Upper nibble 0x4 copies bits [1:0] of the same byte to `port_out`.
- R7: Upper nibble 0x5 loads `duty_code` from bits [2:0]. Upper nibble 0x6 loads `digit_code` from bits [2:0].
- R8: Upper nibble 0x7 loads `all_off` from bit 0 and `all_on` from bit 1.
- R9: After reset, all pointers, `port_out`, `duty_code`, `digit_code`, `all_off`, `all_on` and all write strobes are 0.
- R10: A command byte with upper nibble 0x0 or 0x8..0xF changes no register and starts no stream.
- R11: Raising `link_csn` ends any stream and drops a partly gathered glyph word. The next byte is decoded as a command.
- R12: Each written memory entry produces exactly one strobe, one clock cycle wide, and no two memories are strobed in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| link_clk | input | 1 | Serial shift clock from the host |
| link_din | input | 1 | Serial data, least significant bit first |
| link_csn | input | 1 | Active-low link select |
| chr_we | output | 1 | Character-code memory write strobe |
| chr_addr | output | 4 | Character-code memory write address |
| chr_data | output | 8 | Character code to write |
| pat_we | output | 1 | Glyph memory write strobe |
| pat_addr | output | 3 | Glyph memory write address |
| pat_data | output | 35 | Assembled 35-bit glyph word |
| sym_we | output | 1 | Marker memory write strobe |
| sym_addr | output | 4 | Marker memory write address |
| sym_data | output | 2 | Marker bits to write |
| port_out | output | 2 | Static port outputs |
| duty_code | output | 3 | Duty code |
| digit_code | output | 3 | Digit-count code |
| all_off | output | 1 | Force all display outputs low |
| all_on | output | 1 | Force all display outputs high |

## Verification
The bench builds the block with its default parameters: memory depths of 16, 8 and 16, a 5x7 glyph cell and two synchronizer stages. With the small glyph depth, a 15-byte stream wraps the glyph pointer from 7 back to 0. An 18-byte character stream wraps the 16-entry pointer. With two stages and a shift clock at one eighth of the system clock, each bit is seen once, and partial bytes, select toggles and shift edges while the link is deselected can be placed at chosen bit counts.

// File: rtl/vfd_cmd_pkg.sv
package vfd_cmd_pkg;

  localparam int LINK_BYTE_W = 8;

  typedef enum logic [1:0] {
    MODE_CMD,
    MODE_CHR,
    MODE_PAT,
    MODE_SYM
  } stream_mode_e;

  localparam logic [3:0] OP_CHR   = 4'h1;
  localparam logic [3:0] OP_PAT   = 4'h2;
  localparam logic [3:0] OP_SYM   = 4'h3;
  localparam logic [3:0] OP_PORT  = 4'h4;
  localparam logic [3:0] OP_DUTY  = 4'h5;
  localparam logic [3:0] OP_DIGIT = 4'h6;
  localparam logic [3:0] OP_LAMP  = 4'h7;

  function automatic logic opcode_known(input logic [3:0] op);
    return (op >= OP_CHR) && (op <= OP_LAMP);
  endfunction

endpackage

// File: rtl/vfd_link_rx.sv
module vfd_link_rx #(
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_clk,
  input  logic              link_din,
  input  logic              link_csn,
  output logic              byte_stb,
  output logic [BYTE_W-1:0] byte_data,
  output logic              link_idle
);

  localparam int CNT_W = $clog2(BYTE_W);

  logic [SYNC_STAGES-1:0] clk_sync;
  logic [SYNC_STAGES-1:0] din_sync;
  logic [SYNC_STAGES-1:0] csn_sync;
  logic                   clk_prev;
  logic                   clk_rise;
  logic                   din_s;
  logic [CNT_W-1:0]       bit_cnt;
  logic                   last_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_sync <= '0;
      din_sync <= '0;
      csn_sync <= '1;
      clk_prev <= 1'b0;
    end else begin
      clk_sync <= {clk_sync[SYNC_STAGES-2:0], link_clk};
      din_sync <= {din_sync[SYNC_STAGES-2:0], link_din};
      csn_sync <= {csn_sync[SYNC_STAGES-2:0], link_csn};
      clk_prev <= clk_sync[SYNC_STAGES-1];
    end
  end

  assign clk_rise  = clk_sync[SYNC_STAGES-1] & ~clk_prev;
  assign din_s     = din_sync[SYNC_STAGES-1];
  assign link_idle = csn_sync[SYNC_STAGES-1];
  assign last_bit  = (bit_cnt == CNT_W'(BYTE_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      byte_data <= '0;
      byte_stb  <= 1'b0;
    end else begin
      byte_stb <= 1'b0;
      if (link_idle) begin
        bit_cnt <= '0;
      end else if (clk_rise) begin
        byte_data <= {din_s, byte_data[BYTE_W-1:1]};
        bit_cnt   <= last_bit ? '0 : bit_cnt + 1'b1;
        byte_stb  <= last_bit;
      end
    end
  end

  p_idle_clears_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    link_idle |=> (bit_cnt == '0));

  p_byte_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb |=> !byte_stb);

  p_byte_needs_select_r1: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb |-> $past(!link_idle));

endmodule

// File: rtl/vfd_wr_ptr.sv
module vfd_wr_ptr #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  output logic [AW-1:0] ptr
);

  function automatic logic [AW-1:0] next_slot(input logic [AW-1:0] cur);
    return (cur == AW'(DEPTH - 1)) ? '0 : cur + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (load) begin
      ptr <= load_val;
    end else if (step) begin
      ptr <= next_slot(ptr);
    end
  end

endmodule

// File: rtl/vfd_pattern_packer.sv
module vfd_pattern_packer #(
  parameter int COLS  = 5,
  parameter int ROWS  = 7,
  localparam int WORD_W = COLS * ROWS,
  localparam int COL_W  = $clog2(COLS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              col_stb,
  input  logic [ROWS-1:0]   col_bits,
  output logic              word_done,
  output logic [WORD_W-1:0] word
);

  logic [COLS-2:0][ROWS-1:0] col_q;
  logic [COL_W-1:0]          col_idx;
  logic                      last_col;

  assign last_col  = (col_idx == COL_W'(COLS - 1));
  assign word_done = col_stb & last_col & ~clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_idx <= '0;
      col_q   <= '0;
    end else if (clear) begin
      col_idx <= '0;
    end else if (col_stb) begin
      col_idx <= last_col ? '0 : col_idx + 1'b1;
      for (int k = 0; k < COLS - 1; k++) begin
        if (col_idx == COL_W'(k)) col_q[k] <= col_bits;
      end
    end
  end

  // Column k feeds word bits k, k+COLS, k+2*COLS, ...
  for (genvar k = 0; k < COLS; k++) begin : g_col
    for (genvar j = 0; j < ROWS; j++) begin : g_row
      if (k == COLS - 1) begin : g_live
        assign word[k + COLS * j] = col_bits[j];
      end else begin : g_held
        assign word[k + COLS * j] = col_q[k][j];
      end
    end
  end

  p_col_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, col_idx} < (COL_W + 1)'(COLS));

  p_clear_restarts_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (col_idx == '0));

endmodule

// File: rtl/vfd_cmd_decode.sv
module vfd_cmd_decode
  import vfd_cmd_pkg::*;
#(
  parameter int CHR_DEPTH = 16,
  parameter int PAT_DEPTH = 8,
  parameter int SYM_DEPTH = 16,
  parameter int PAT_COLS  = 5,
  parameter int PAT_ROWS  = 7,
  parameter int SYM_W     = 2,
  parameter int PORT_W    = 2,
  parameter int CODE_W    = 3,
  localparam int CHR_AW   = $clog2(CHR_DEPTH),
  localparam int PAT_AW   = $clog2(PAT_DEPTH),
  localparam int SYM_AW   = $clog2(SYM_DEPTH),
  localparam int PAT_W    = PAT_COLS * PAT_ROWS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   byte_stb,
  input  logic [LINK_BYTE_W-1:0] byte_data,
  input  logic                   link_idle,
  output logic                   chr_we,
  output logic [CHR_AW-1:0]      chr_addr,
  output logic [LINK_BYTE_W-1:0] chr_data,
  output logic                   pat_we,
  output logic [PAT_AW-1:0]      pat_addr,
  output logic [PAT_W-1:0]       pat_data,
  output logic                   sym_we,
  output logic [SYM_AW-1:0]      sym_addr,
  output logic [SYM_W-1:0]       sym_data,
  output logic [PORT_W-1:0]      port_out,
  output logic [CODE_W-1:0]      duty_code,
  output logic [CODE_W-1:0]      digit_code,
  output logic                   all_off,
  output logic                   all_on
);

  stream_mode_e      mode_q;
  logic [3:0]        op;
  logic              cmd_byte;
  logic              chr_load, chr_step;
  logic              pat_load, pat_byte;
  logic              sym_load, sym_step;
  logic              word_done;
  logic [PAT_W-1:0]  word;
  logic [CHR_AW-1:0] chr_ptr;
  logic [PAT_AW-1:0] pat_ptr;
  logic [SYM_AW-1:0] sym_ptr;
  logic [PORT_W+2*CODE_W+1:0] reg_view;

  assign op       = byte_data[7:4];
  assign cmd_byte = byte_stb && (mode_q == MODE_CMD);
  assign chr_load = cmd_byte && (op == OP_CHR);
  assign pat_load = cmd_byte && (op == OP_PAT);
  assign sym_load = cmd_byte && (op == OP_SYM);
  assign chr_step = byte_stb && (mode_q == MODE_CHR);
  assign pat_byte = byte_stb && (mode_q == MODE_PAT);
  assign sym_step = byte_stb && (mode_q == MODE_SYM);
  assign reg_view = {port_out, duty_code, digit_code, all_off, all_on};

  vfd_wr_ptr #(.DEPTH(CHR_DEPTH)) u_chr_ptr (
    .clk(clk), .rst_n(rst_n), .load(chr_load),
    .load_val(byte_data[CHR_AW-1:0]), .step(chr_step), .ptr(chr_ptr)
  );

  vfd_wr_ptr #(.DEPTH(PAT_DEPTH)) u_pat_ptr (
    .clk(clk), .rst_n(rst_n), .load(pat_load),
    .load_val(byte_data[PAT_AW-1:0]), .step(word_done), .ptr(pat_ptr)
  );

  vfd_wr_ptr #(.DEPTH(SYM_DEPTH)) u_sym_ptr (
    .clk(clk), .rst_n(rst_n), .load(sym_load),
    .load_val(byte_data[SYM_AW-1:0]), .step(sym_step), .ptr(sym_ptr)
  );

  vfd_pattern_packer #(.COLS(PAT_COLS), .ROWS(PAT_ROWS)) u_packer (
    .clk(clk), .rst_n(rst_n), .clear(pat_load | link_idle),
    .col_stb(pat_byte), .col_bits(byte_data[PAT_ROWS-1:0]),
    .word_done(word_done), .word(word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= MODE_CMD;
      chr_we     <= 1'b0;
      chr_addr   <= '0;
      chr_data   <= '0;
      pat_we     <= 1'b0;
      pat_addr   <= '0;
      pat_data   <= '0;
      sym_we     <= 1'b0;
      sym_addr   <= '0;
      sym_data   <= '0;
      port_out   <= '0;
      duty_code  <= '0;
      digit_code <= '0;
      all_off    <= 1'b0;
      all_on     <= 1'b0;
    end else begin
      chr_we <= chr_step;
      pat_we <= word_done;
      sym_we <= sym_step;
      if (chr_step) begin
        chr_addr <= chr_ptr;
        chr_data <= byte_data;
      end
      if (word_done) begin
        pat_addr <= pat_ptr;
        pat_data <= word;
      end
      if (sym_step) begin
        sym_addr <= sym_ptr;
        sym_data <= byte_data[SYM_W-1:0];
      end
      if (cmd_byte) begin
        case (op)
          OP_CHR:   mode_q     <= MODE_CHR;
          OP_PAT:   mode_q     <= MODE_PAT;
          OP_SYM:   mode_q     <= MODE_SYM;
          OP_PORT:  port_out   <= byte_data[PORT_W-1:0];
          OP_DUTY:  duty_code  <= byte_data[CODE_W-1:0];
          OP_DIGIT: digit_code <= byte_data[CODE_W-1:0];
          OP_LAMP: begin
            all_off <= byte_data[0];
            all_on  <= byte_data[1];
          end
          default: ;
        endcase
      end
      if (link_idle) mode_q <= MODE_CMD;
    end
  end

  p_strobe_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({chr_we, pat_we, sym_we}));

  p_chr_ptr_adv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    chr_we |-> (chr_ptr == CHR_AW'(chr_addr + 1'b1)));

  p_pat_ptr_adv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pat_we |-> (pat_ptr == PAT_AW'(pat_addr + 1'b1)));

  p_sym_ptr_adv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sym_we |-> (sym_ptr == SYM_AW'(sym_addr + 1'b1)));

  p_idle_cancels_stream_r11: assert property (@(posedge clk) disable iff (!rst_n)
    link_idle |=> (mode_q == MODE_CMD));

  p_unknown_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_byte && !opcode_known(op)) |=> ((mode_q == MODE_CMD) && $stable(reg_view)));

  p_stream_keeps_regs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_stb && (mode_q != MODE_CMD)) |=> $stable(reg_view));

endmodule

// File: rtl/vfd_cmd_rx.sv
module vfd_cmd_rx
  import vfd_cmd_pkg::*;
#(
  parameter int CHR_DEPTH   = 16,
  parameter int PAT_DEPTH   = 8,
  parameter int SYM_DEPTH   = 16,
  parameter int PAT_COLS    = 5,
  parameter int PAT_ROWS    = 7,
  parameter int SYM_W       = 2,
  parameter int PORT_W      = 2,
  parameter int CODE_W      = 3,
  parameter int SYNC_STAGES = 2,
  localparam int CHR_AW     = $clog2(CHR_DEPTH),
  localparam int PAT_AW     = $clog2(PAT_DEPTH),
  localparam int SYM_AW     = $clog2(SYM_DEPTH),
  localparam int PAT_W      = PAT_COLS * PAT_ROWS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   link_clk,
  input  logic                   link_din,
  input  logic                   link_csn,
  output logic                   chr_we,
  output logic [CHR_AW-1:0]      chr_addr,
  output logic [LINK_BYTE_W-1:0] chr_data,
  output logic                   pat_we,
  output logic [PAT_AW-1:0]      pat_addr,
  output logic [PAT_W-1:0]       pat_data,
  output logic                   sym_we,
  output logic [SYM_AW-1:0]      sym_addr,
  output logic [SYM_W-1:0]       sym_data,
  output logic [PORT_W-1:0]      port_out,
  output logic [CODE_W-1:0]      duty_code,
  output logic [CODE_W-1:0]      digit_code,
  output logic                   all_off,
  output logic                   all_on
);

  logic                   byte_stb;
  logic [LINK_BYTE_W-1:0] byte_data;
  logic                   link_idle;

  vfd_link_rx #(.SYNC_STAGES(SYNC_STAGES), .BYTE_W(LINK_BYTE_W)) u_link (
    .clk(clk), .rst_n(rst_n), .link_clk(link_clk), .link_din(link_din),
    .link_csn(link_csn), .byte_stb(byte_stb), .byte_data(byte_data),
    .link_idle(link_idle)
  );

  vfd_cmd_decode #(
    .CHR_DEPTH(CHR_DEPTH), .PAT_DEPTH(PAT_DEPTH), .SYM_DEPTH(SYM_DEPTH),
    .PAT_COLS(PAT_COLS), .PAT_ROWS(PAT_ROWS), .SYM_W(SYM_W),
    .PORT_W(PORT_W), .CODE_W(CODE_W)
  ) u_decode (
    .clk(clk), .rst_n(rst_n), .byte_stb(byte_stb), .byte_data(byte_data),
    .link_idle(link_idle),
    .chr_we(chr_we), .chr_addr(chr_addr), .chr_data(chr_data),
    .pat_we(pat_we), .pat_addr(pat_addr), .pat_data(pat_data),
    .sym_we(sym_we), .sym_addr(sym_addr), .sym_data(sym_data),
    .port_out(port_out), .duty_code(duty_code), .digit_code(digit_code),
    .all_off(all_off), .all_on(all_on)
  );

endmodule

// File: tb/vfd_cmd_rx_bench.sv
`timescale 1ns/1ps
module vfd_cmd_rx_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic link_clk = 1'b0;
  logic link_din = 1'b0;
  logic link_csn = 1'b1;

  logic        chr_we;
  logic [3:0]  chr_addr;
  logic [7:0]  chr_data;
  logic        pat_we;
  logic [2:0]  pat_addr;
  logic [34:0] pat_data;
  logic        sym_we;
  logic [3:0]  sym_addr;
  logic [1:0]  sym_data;
  logic [1:0]  port_out;
  logic [2:0]  duty_code;
  logic [2:0]  digit_code;
  logic        all_off;
  logic        all_on;

  always #2.5 clk = ~clk;

  vfd_cmd_rx u_vfd_cmd_rx (
    .clk(clk), .rst_n(rst_n), .link_clk(link_clk), .link_din(link_din),
    .link_csn(link_csn),
    .chr_we(chr_we), .chr_addr(chr_addr), .chr_data(chr_data),
    .pat_we(pat_we), .pat_addr(pat_addr), .pat_data(pat_data),
    .sym_we(sym_we), .sym_addr(sym_addr), .sym_data(sym_data),
    .port_out(port_out), .duty_code(duty_code), .digit_code(digit_code),
    .all_off(all_off), .all_on(all_on)
  );

  int n_checks = 0;
  int n_errors = 0;
  int n_writes = 0;
  bit settled  = 1'b0;
  bit done     = 1'b0;

  // Behavioural reference state
  int m_mode = 0;   // 0 command, 1 char, 2 glyph, 3 marker
  int m_cptr = 0, m_pptr = 0, m_sptr = 0, m_col = 0;
  int m_port = 0, m_duty = 0, m_digit = 0, m_off = 0, m_on = 0;
  logic [7:0] m_cols [5];
  int q_kind [$];
  int q_addr [$];
  logic [63:0] q_data [$];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_regs();
    return 64'((m_port << 8) | (m_duty << 5) | (m_digit << 2) | (m_off << 1) | m_on);
  endfunction

  function automatic logic [63:0] act_regs();
    return 64'({port_out, duty_code, digit_code, all_off, all_on});
  endfunction

  task automatic expect_write(input int kind, input int addr, input logic [63:0] data);
    q_kind.push_back(kind);
    q_addr.push_back(addr);
    q_data.push_back(data);
  endtask

  task automatic model_byte(input logic [7:0] b);
    logic [63:0] w;
    case (m_mode)
      0: begin
        case (int'(b[7:4]))
          1: begin m_mode = 1; m_cptr = int'(b[3:0]); end
          2: begin m_mode = 2; m_pptr = int'(b[2:0]); m_col = 0; end
          3: begin m_mode = 3; m_sptr = int'(b[3:0]); end
          4: m_port  = int'(b[1:0]);
          5: m_duty  = int'(b[2:0]);
          6: m_digit = int'(b[2:0]);
          7: begin m_off = int'(b[0]); m_on = int'(b[1]); end
          default: ;
        endcase
      end
      1: begin
        expect_write(1, m_cptr, 64'(b));
        m_cptr = (m_cptr + 1) % 16;
      end
      3: begin
        expect_write(3, m_sptr, 64'(b & 8'h03));
        m_sptr = (m_sptr + 1) % 16;
      end
      default: begin
        m_cols[m_col] = b;
        m_col = m_col + 1;
        if (m_col == 5) begin
          w = '0;
          for (int k = 0; k < 5; k++)
            for (int j = 0; j < 7; j++)
              w[k + 5 * j] = m_cols[k][j];
          expect_write(2, m_pptr, w);
          m_pptr = (m_pptr + 1) % 8;
          m_col = 0;
        end
      end
    endcase
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk) link_din = b;
    repeat (4) @(negedge clk);
    link_clk = 1'b1;
    repeat (4) @(negedge clk);
    link_clk = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    settled = 1'b0;
    model_byte(b);
    for (int i = 0; i < 8; i++) send_bit(b[i]);
    repeat (6) @(negedge clk);
    settled = 1'b1;
  endtask

  task automatic select_off();
    settled = 1'b0;
    @(negedge clk) link_csn = 1'b1;
    repeat (6) @(negedge clk);
    m_mode = 0;
    m_col = 0;
    settled = 1'b1;
  endtask

  task automatic select_on();
    @(negedge clk) link_csn = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic check_write(input int kind, input int addr, input logic [63:0] data);
    string tag;
    int ek, ea;
    logic [63:0] ed;
    n_writes++;
    tag = (kind == 1) ? "R3 char write" : (kind == 2) ? "R4 glyph write" : "R5 marker write";
    if (q_kind.size() == 0) begin
      chk("R12 unexpected strobe", 64'(kind), 64'd0);
    end else begin
      ek = q_kind.pop_front();
      ea = q_addr.pop_front();
      ed = q_data.pop_front();
      chk({tag, " kind"}, 64'(kind), 64'(ek));
      chk({tag, " addr"}, 64'(addr), 64'(ea));
      chk({tag, " data"}, data, ed);
    end
  endtask

  // Compared on every clock
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R12 single strobe", 64'(int'(chr_we) + int'(pat_we) + int'(sym_we) > 1), 64'd0);
      if (chr_we) check_write(1, int'(chr_addr), 64'(chr_data));
      if (pat_we) check_write(2, int'(pat_addr), 64'(pat_data));
      if (sym_we) check_write(3, int'(sym_addr), 64'(sym_data));
      if (settled) chk("R6 R7 R8 R10 registers", act_regs(), exp_regs());
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_errors++;
      n_checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    int w0;
    repeat (4) @(negedge clk);
    chk("R9 reset registers", act_regs(), 64'd0);
    chk("R9 reset strobes", 64'({chr_we, pat_we, sym_we}), 64'd0);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 after release", act_regs(), 64'd0);
    settled = 1'b1;

    // Register commands
    select_on();
    send_byte(8'h43); chk("R6 port", 64'(port_out), 64'd3);
    send_byte(8'h5D); chk("R7 duty", 64'(duty_code), 64'd5);
    send_byte(8'h6E); chk("R7 digit", 64'(digit_code), 64'd6);
    send_byte(8'h71); chk("R8 off", 64'({all_off, all_on}), 64'b10);
    send_byte(8'h7E); chk("R8 on", 64'({all_off, all_on}), 64'b01);
    send_byte(8'h41); chk("R6 port low bit", 64'(port_out), 64'd1);

    // Unknown opcodes
    w0 = n_writes;
    send_byte(8'h0A); send_byte(8'h8F); send_byte(8'hF3);
    send_byte(8'h15);  // would be char data if a stream had opened
    chk("R10 unknown no regs", act_regs(), exp_regs());
    select_off();
    chk("R10 unknown no writes", 64'(n_writes), 64'(w0));

    // Character stream with wrap and command-like data
    select_on();
    send_byte(8'h1E);
    for (int i = 0; i < 18; i++) send_byte(8'(8'hA0 + i * 7));
    send_byte(8'h43);
    chk("R3 stream keeps port", 64'(port_out), 64'd1);
    select_off();
    chk("R12 char writes drained", 64'(q_kind.size()), 64'd0);

    // Marker stream
    select_on();
    send_byte(8'h3F);
    send_byte(8'hFD); send_byte(8'h02); send_byte(8'h81);
    select_off();
    chk("R5 marker writes drained", 64'(q_kind.size()), 64'd0);

    // Glyph stream with wrap
    select_on();
    send_byte(8'h26);
    for (int i = 0; i < 15; i++) send_byte(8'(8'h5A ^ (i * 8'h3B)));
    select_off();
    chk("R4 glyph writes drained", 64'(q_kind.size()), 64'd0);

    // Select release cancels a partial glyph
    select_on();
    w0 = n_writes;
    send_byte(8'h20);
    send_byte(8'h7F); send_byte(8'h01); send_byte(8'hFF);
    select_off();
    select_on();
    send_byte(8'h52);
    chk("R11 byte after release is command", 64'(duty_code), 64'd2);
    chk("R11 partial glyph dropped", 64'(n_writes), 64'(w0));
    send_byte(8'h21);
    send_byte(8'h01); send_byte(8'h02); send_byte(8'h04);
    send_byte(8'h08); send_byte(8'hC0);
    select_off();
    chk("R4 fresh glyph written", 64'(n_writes), 64'(w0 + 1));

    // Partial byte discarded
    select_on();
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    select_off();
    select_on();
    send_byte(8'h42);
    chk("R2 frame restarts", 64'(port_out), 64'd2);
    select_off();

    // Shift edges while deselected
    w0 = n_writes;
    for (int i = 0; i < 8; i++) send_bit(1'b1);
    for (int i = 0; i < 8; i++) send_bit(i == 0 || i == 6);
    repeat (6) @(negedge clk);
    chk("R1 deselected no change", act_regs(), exp_regs());
    chk("R1 deselected no writes", 64'(n_writes), 64'(w0));
    select_on();
    send_byte(8'h47);
    chk("R1 lsb first", 64'(port_out), 64'd3);
    select_off();

    repeat (10) @(negedge clk);
    chk("R12 all expected writes seen", 64'(q_kind.size()), 64'd0);
    done = 1'b1;
    finish_run();
  end

endmodule